// File: doc/BRIEF.md
# Page-Buffered Serial Memory Write Engine

This block sits behind a serial-memory command decoder and turns the data phase of a write command into one timed programming cycle. The decoder hands it a start address, then a strobe for each data byte that has fully arrived. When chip select goes high, it sends a single end pulse and says whether the last byte was cut short. The engine gathers the bytes into a page-sized staging buffer. The in-page offset advances after every byte and wraps around inside the page, while the page number stays fixed.

At the end of the transaction the engine decides whether to program. Programming needs all of the following: at least one complete byte, no partial trailing byte, the write-enable latch set, a page outside the range guarded by the two protection bits, and the write-protect pin high for the whole transaction. If the write goes ahead, a busy flag stays high for a fixed number of clocks. In the last cycle of that window only the bytes loaded during the transaction are copied into a register-modelled array. At the same moment a one-cycle pulse tells the decoder to clear its write-enable latch. The array can be read at any time through a combinational read port.

Top module: `pgw_engine`

## Requirements
- R1: After reset, busy and the latch-clear pulse are 0 and every array byte reads 0.
- R2: Successive data bytes land at successive offsets of the page selected by the start address; the upper address bits never change during loading.
- R3: A byte loaded after offset PAGE_BYTES-1 goes to offset 0 of the same page and overwrites any byte loaded there earlier in the same transaction.
- R4: Nothing is programmed before the end pulse. Busy rises in the cycle after an accepted end pulse, and array contents stay at their old values until the cycle window finishes.
- R5: Busy stays high for exactly WR_CYCLE_CLKS clock cycles per programming cycle.
- R6: The latch-clear output pulses high for exactly one cycle, in the first cycle after busy falls. In that same cycle the new data is readable.
- R7: Protection field bp: 2'b00 guards nothing; 2'b01 guards the top quarter (addresses 0xC0–0xFF for an 8-bit address); 2'b10 guards the top half (0x80–0xFF); 2'b11 guards everything. A write to a guarded page starts no cycle and changes no data.
- R8: If wp_n is low in any cycle from the start strobe through the end pulse, the transaction starts no cycle.
- R9: wp_n going low while busy is high has no effect on the cycle or the data it programs.
- R10: Page bytes that were not loaded in a transaction keep their previous contents.
- R11: An end pulse with zero loaded bytes, or with end_partial high, starts no cycle and gives no latch-clear pulse.
- R12: An end pulse while wel is 0 starts no cycle.
- R13: Start, byte and end strobes that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Pulse: a write data phase begins at start_addr |
| start_addr | input | ADDR_W | First byte address of the write |
| byte_vld | input | 1 | Pulse: byte_data holds one complete data byte |
| byte_data | input | 8 | Data byte |
| xfer_end | input | 1 | Pulse: chip select went high |
| end_partial | input | 1 | With xfer_end: a trailing byte was incomplete |
| bp | input | 2 | Block protection field |
| wel | input | 1 | Write-enable latch from the decoder |
| wp_n | input | 1 | Write-protect pin, active low |
| rd_addr | input | ADDR_W | Array read address |
| busy | output | 1 | Internal programming cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
Two situations are hard to reach from the ports. The first is traffic that arrives during the timed cycle, since busy hides the engine's internal state. The bench follows busy cycle by cycle. At fixed points inside the window it pulls wp_n low or fires a complete stray transaction aimed at another page. Afterwards it compares the whole array against its own model to show that neither one left any trace. The second is wrap-around overwrite. It is reached by loading more bytes than a page holds, starting near the page end, so that later bytes visibly replace earlier ones at offset 0 upward.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;

  typedef enum logic [1:0] {
    GUARD_NONE = 2'b00,
    GUARD_QTR  = 2'b01,
    GUARD_HALF = 2'b10,
    GUARD_ALL  = 2'b11
  } pgw_guard_e;
endpackage

// File: rtl/pgw_prot.sv
module pgw_prot #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              hit
);
  import pgw_pkg::*;

  pgw_guard_e mode;

  always_comb begin
    mode = pgw_guard_e'(bp);
    unique case (mode)
      GUARD_NONE: hit = 1'b0;
      GUARD_QTR:  hit = &addr[ADDR_W-1 -: 2];
      GUARD_HALF: hit = addr[ADDR_W-1];
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [OFS_W-1:0]        ofs_init,
  input  logic                    wr,
  input  logic [7:0]              wdata,
  output logic [PAGE_BYTES*8-1:0] data,
  output logic [PAGE_BYTES-1:0]   mask,
  output logic                    any
);
  logic [OFS_W-1:0]      ptr_q, ptr_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [PAGE_BYTES-1:0] sel;

  always_comb begin
    ptr_d  = ptr_q;
    mask_d = mask_q;
    sel    = '0;
    if (clr) begin
      ptr_d  = ofs_init;
      mask_d = '0;
    end else if (wr) begin
      sel[ptr_q]    = 1'b1;
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q <= '0;
      else if (sel[g]) slot_q <= wdata;
    end
    assign data[g*8 +: 8] = slot_q;
  end

  assign mask = mask_q;
  assign any  = |mask_q;
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [PAGE_W-1:0]       page,
  input  logic [PAGE_BYTES-1:0]   mask,
  input  logic [PAGE_BYTES*8-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (we) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask[i]) mem[{page, OFS_W'(i)}] <= wdata[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine #(
  parameter int ADDR_W        = 8,
  parameter int PAGE_BYTES    = 16,
  parameter int WR_CYCLE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              xfer_end,
  input  logic              end_partial,
  input  logic [1:0]        bp,
  input  logic              wel,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              wel_clr,
  output logic [7:0]        rd_data
);
  import pgw_pkg::*;

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(WR_CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLE_CLKS - 1);

  pgw_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              cancel_q, cancel_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              clr_q, clr_d;

  logic                    take_start, take_byte, commit;
  logic                    guard_hit, buf_any;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_mask;

  assign take_start = wr_start && (state_q != ST_PROG);
  assign take_byte  = byte_vld && (state_q == ST_LOAD) && !wr_start;

  pgw_prot #(.ADDR_W(ADDR_W)) u_prot (
    .addr (ADDR_W'({page_q, {OFS_W{1'b0}}})),
    .bp   (bp),
    .hit  (guard_hit)
  );

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (take_start),
    .ofs_init (start_addr[OFS_W-1:0]),
    .wr       (take_byte),
    .wdata    (byte_data),
    .data     (buf_data),
    .mask     (buf_mask),
    .any      (buf_any)
  );

  always_comb begin
    state_d  = state_q;
    page_d   = page_q;
    cancel_d = cancel_q;
    cnt_d    = cnt_q;
    clr_d    = 1'b0;
    commit   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_LOAD: begin
        if (take_start) begin
          state_d  = ST_LOAD;
          page_d   = start_addr[ADDR_W-1:OFS_W];
          cancel_d = !wp_n;
        end else if (state_q == ST_LOAD) begin
          if (!wp_n) cancel_d = 1'b1;
          if (xfer_end) begin
            if (buf_any && !end_partial && !cancel_q && wp_n && wel && !guard_hit) begin
              state_d = ST_PROG;
              cnt_d   = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      end
      ST_PROG: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_IDLE;
          commit  = 1'b1;
          clr_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      cancel_q <= 1'b0;
      cnt_q    <= '0;
      clr_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      page_q   <= page_d;
      cancel_q <= cancel_d;
      cnt_q    <= cnt_d;
      clr_q    <= clr_d;
    end
  end

  pgw_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (commit),
    .page    (page_q),
    .mask    (buf_mask),
    .wdata   (buf_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign busy    = (state_q == ST_PROG);
  assign wel_clr = clr_q;
endmodule

// File: rtl/pgw_engine_chk.sv
module pgw_engine_chk #(
  parameter int WR_CYCLE_CLKS = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel_clr,
  input logic       xfer_end,
  input logic [1:0] bp,
  input logic       wel,
  input logic       wp_n
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == WR_CYCLE_CLKS);
  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < WR_CYCLE_CLKS);
  // R6
  clr_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> !busy && $past(busy));
  // R6
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
  // R4
  start_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(xfer_end));
  // R7
  guard_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bp) != 2'b11);
  // R12
  wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R8
  wp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wp_n));
endmodule

bind pgw_engine pgw_engine_chk #(.WR_CYCLE_CLKS(WR_CYCLE_CLKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .wel_clr  (wel_clr),
  .xfer_end (xfer_end),
  .bp       (bp),
  .wel      (wel),
  .wp_n     (wp_n)
);

// File: tb/pgw_engine_tb.sv
module pgw_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 20;

  typedef struct packed {
    logic [7:0] addr;
    logic [5:0] n;
    logic [1:0] bp;
    logic [1:0] mode;   // 0 plain, 1 wp low while loading, 2 wp low while busy, 3 stray traffic while busy
    logic       wel;
    logic       part;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'h10, 6'd1,  2'd0, 2'd0, 1'b1, 1'b0},  // R2
    '{8'h23, 6'd4,  2'd0, 2'd0, 1'b1, 1'b0},  // R2
    '{8'h3C, 6'd6,  2'd0, 2'd0, 1'b1, 1'b0},  // R3
    '{8'h40, 6'd20, 2'd0, 2'd0, 1'b1, 1'b0},  // R3
    '{8'hC5, 6'd2,  2'd1, 2'd0, 1'b1, 1'b0},  // R7
    '{8'hB0, 6'd2,  2'd1, 2'd0, 1'b1, 1'b0},  // R7
    '{8'h90, 6'd2,  2'd2, 2'd0, 1'b1, 1'b0},  // R7
    '{8'h70, 6'd2,  2'd2, 2'd0, 1'b1, 1'b0},  // R7
    '{8'h00, 6'd2,  2'd3, 2'd0, 1'b1, 1'b0},  // R7
    '{8'h50, 6'd3,  2'd0, 2'd1, 1'b1, 1'b0},  // R8
    '{8'h60, 6'd3,  2'd0, 2'd2, 1'b1, 1'b0},  // R9
    '{8'h14, 6'd0,  2'd0, 2'd0, 1'b1, 1'b0},  // R11
    '{8'h18, 6'd3,  2'd0, 2'd0, 1'b1, 1'b1},  // R11
    '{8'h1A, 6'd2,  2'd0, 2'd0, 1'b0, 1'b0},  // R12
    '{8'h12, 6'd2,  2'd0, 2'd3, 1'b1, 1'b0}   // R13, R10
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_start, byte_vld, xfer_end, end_partial, wel, wp_n;
  logic [7:0] start_addr, byte_data, rd_addr, rd_data;
  logic [1:0] bp;
  logic       busy, wel_clr;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgw_engine #(.ADDR_W(8), .PAGE_BYTES(16), .WR_CYCLE_CLKS(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .xfer_end(xfer_end),
    .end_partial(end_partial), .bp(bp), .wel(wel), .wp_n(wp_n),
    .rd_addr(rd_addr), .busy(busy), .wel_clr(wel_clr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit guarded(input logic [7:0] a, input logic [1:0] b);
    case (b)
      2'd0: return 1'b0;
      2'd1: return a >= 8'hC0;
      2'd2: return a >= 8'h80;
      default: return 1'b1;
    endcase
  endfunction

  task automatic compare_array(input string req);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      #1;
      if (rd_data !== model[a]) begin
        if (first < 0) first = a;
        bad++;
      end
    end
    check(bad == 0, req, bad, 0);
    if (first >= 0) $display("  first mismatch at address %0h", first);
  endtask

  task automatic run_vec(input vec_t v, input int k);
    logic [7:0] base = 8'(k * 16 + 1);
    bit         go;
    string      tag;
    logic [7:0] old;
    int         len;
    go = (v.n != 0) && !v.part && v.wel && (v.mode != 2'd1) && !guarded(v.addr, v.bp);
    if (v.n == 0 || v.part)   tag = "R11";
    else if (!v.wel)          tag = "R12";
    else if (v.mode == 2'd1)  tag = "R8";
    else if (guarded(v.addr, v.bp)) tag = "R7";
    else if (v.mode == 2'd2)  tag = "R9";
    else if (v.mode == 2'd3)  tag = "R13";
    else if (v.n > 16)        tag = "R3";
    else                      tag = "R2";
    old = model[v.addr];

    @(negedge clk);
    bp = v.bp; wel = v.wel; wr_start = 1'b1; start_addr = v.addr;
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < int'(v.n); i++) begin
      byte_vld = 1'b1; byte_data = base + 8'(i);
      if (v.mode == 2'd1 && i == 1) wp_n = 1'b0;
      @(negedge clk);
      byte_vld = 1'b0; wp_n = 1'b1;
    end
    check(busy == 1'b0, "R4", busy, 0);  // nothing before the end pulse
    xfer_end = 1'b1; end_partial = v.part;
    @(negedge clk);
    xfer_end = 1'b0; end_partial = 1'b0;
    check(busy == go, tag, busy, go);

    if (go) begin
      len = 0;
      while (busy) begin
        if (len == 0) begin
          rd_addr = v.addr; #1;
          check(rd_data == old, "R4", rd_data, old);
        end
        if (v.mode == 2'd2 && len == 1) wp_n = 1'b0;
        if (v.mode == 2'd3 && len == 2) begin
          wr_start = 1'b1; start_addr = v.addr ^ 8'h80;
          byte_vld = 1'b1; byte_data = 8'hEE; xfer_end = 1'b1;
        end
        if (v.mode == 2'd3 && len == 3) begin
          wr_start = 1'b0; byte_vld = 1'b0; xfer_end = 1'b0;
        end
        @(negedge clk);
        len++;
      end
      check(len == WCYC, "R5", len, WCYC);
      check(wel_clr == 1'b1, "R6", wel_clr, 1);
      wp_n = 1'b1;
      for (int i = 0; i < int'(v.n); i++)
        model[{v.addr[7:4], 4'(v.addr[3:0] + 4'(i))}] = base + 8'(i);
      rd_addr = {v.addr[7:4], 4'(v.addr[3:0] + 4'(v.n - 1))}; #1;
      check(rd_data == model[rd_addr], "R6", rd_data, model[rd_addr]);
      @(negedge clk);
      check(wel_clr == 1'b0, "R6", wel_clr, 0);
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R13", busy, 0);  // stray traffic started nothing
    end else begin
      len = 0;
      repeat (3) begin
        @(negedge clk);
        if (busy || wel_clr) len++;
      end
      check(len == 0, tag, len, 0);
    end
    compare_array(go ? "R10" : tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_start = 1'b0; byte_vld = 1'b0; xfer_end = 1'b0; end_partial = 1'b0;
    wel = 1'b0; wp_n = 1'b1; bp = 2'd0;
    start_addr = '0; byte_data = '0; rd_addr = 8'h55;
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(busy == 1'b0, "R1", busy, 0);
    check(wel_clr == 1'b0, "R1", wel_clr, 0);
    #1;
    check(rd_data == 8'h00, "R1", rd_data, 0);
    compare_array("R1");

    for (int k = 0; k < NV; k++) run_vec(VEC[k], k);

    // R13: an end pulse with no open transaction is ignored
    @(negedge clk);
    wel = 1'b1; byte_vld = 1'b1; byte_data = 8'h77; xfer_end = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; xfer_end = 1'b0;
    check(busy == 1'b0, "R13", busy, 0);
    compare_array("R13");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule